// File: doc/BRIEF.md
# Fused Wiper Setting Controller

This block holds the tap codes for two 8-bit resistor-ladder channels and decides which code each ladder sees. There are three candidate sources for a channel's code. The first is a volatile working register that the bus writes. The second is a permanent image that one fuse-burn sequence stores. The third is a temporary overwrite value, which replaces the permanent image for as long as overwrite mode stays active. A bus front end upstream decodes each transfer into a single-cycle command. The command carries a channel index, a shutdown bit, a program bit, an overwrite bit and a data byte.

The fuse array sits outside the block. At reset the block reads the array's stored status and image. A program command then starts exactly one burn window of a parameterised length. For that whole window the block holds the burn enable high and presents the codes to be stored. On the last cycle of the window it samples a pass/fail input from the array. After a burn attempt, or after a power-up with blown fuses, the working register no longer drives the outputs. Overwrite mode can still adjust the channels until the mode is cleared or power is cycled.

Top module: `otp_wiper_ctrl`

## Requirements
- R1: In a reset cycle (rst_n low at a rising edge) the block reads `fuse_state_i`. Status becomes 00 for 00, 11 for 11, and 10 for any other value. Each channel's code becomes its `fuse_img_i` byte (channel n at bits n*8 upward) when the state is 11, and midscale 0x80 otherwise. Shutdown and busy read 0.
- R2: While status is 00, an accepted command with the program bit 0 writes its data into the selected channel's working register. The new code appears at that channel's output after the edge that accepts the command. Any number of writes is allowed, and the overwrite bit changes nothing here.
- R3: An accepted program command while status is 00 raises `busy_o` and `burn_en_o` for exactly BURN_CYCLES cycles. During that window `burn_data_o` carries the working codes, channel 0 in the low byte. The command's other fields are not applied, overwrite mode is cleared, and every command that arrives while busy is ignored.
- R4: On the last cycle of the window the block samples `fuse_pass_i`. If it is 1, status becomes 11 and the burned codes become the fused codes. If it is 0, status becomes 10 and both fused codes become 0x80.
- R5: Once status is not 00, a program command is ignored entirely. Busy and burn enable stay low, and no output or mode changes.
- R6: `status_o` only ever takes the values 00 (blank), 10 (failed burn) or 11 (burned). Once it leaves 00 it does not change until the next reset.
- R7: While status is not 00, an accepted command with the overwrite bit 1 sets overwrite mode. The command's data drives the selected channel. A channel not yet written since overwrite mode was entered shows its fused code.
- R8: While status is not 00 and overwrite mode is off, each output shows its fused code. A data write with the overwrite bit 0 turns overwrite mode off and does not change any output.
- R9: Overwrite mode does not survive a reset. After reset the outputs show the fused codes.
- R10: Every accepted command with the program bit 0 loads the shutdown flag from its shutdown bit. While the flag is set, every code output reads 0x00. Data written during shutdown is stored, and it appears once a later command clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| cmd_valid_i | input | 1 | Decoded command present this cycle |
| cmd_chan_i | input | 1 | Channel index |
| cmd_shdn_i | input | 1 | Shutdown bit |
| cmd_prog_i | input | 1 | Program (burn) bit |
| cmd_ovr_i | input | 1 | Overwrite bit |
| cmd_data_i | input | 8 | Data byte |
| fuse_state_i | input | 2 | Stored status read from the fuse array |
| fuse_img_i | input | 16 | Stored codes read from the fuse array |
| fuse_pass_i | input | 1 | Burn result from the fuse array, sampled on the last window cycle |
| burn_en_o | output | 1 | Burn enable to the fuse array |
| burn_data_o | output | 16 | Codes to burn |
| busy_o | output | 1 | Burn window in progress |
| status_o | output | 2 | Programming status |
| shdn_o | output | 1 | Shutdown flag |
| code_o | output | 16 | Per-channel tap code, channel 0 in the low byte |

## Verification
The assertions check several rules on every cycle. Status stays within its three legal values and freezes once it leaves blank. A burn never runs on a locked part, and a window always ends in a non-blank status. The shutdown and overwrite modes stay frozen during a burn. A locked channel with neither overwrite nor shutdown active holds its code steady. The fused copy never moves once the part is locked. Other behaviour only the bench's scenarios can show, because it needs a sequence of commands and resets. That covers the exact window length, the codes handed to the fuse array, the fallback to fused codes when overwrite is cleared or power is cycled, and the midscale result of a failed burn.

// File: rtl/otp_wiper_pkg.sv
package otp_wiper_pkg;
    localparam logic [1:0] ST_BLANK = 2'b00;
    localparam logic [1:0] ST_FATAL = 2'b10;
    localparam logic [1:0] ST_GOOD  = 2'b11;
endpackage

// File: rtl/otp_burn_seq.sv
module otp_burn_seq
    import otp_wiper_pkg::*;
#(
    parameter int BURN_CYCLES = 80_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] state_init_i,
    input  logic       start_i,
    input  logic       fuse_pass_i,
    output logic       busy_o,
    output logic       done_o,
    output logic [1:0] status_o
);
    localparam int CNT_W = (BURN_CYCLES > 2) ? $clog2(BURN_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BURN_CYCLES - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       status;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [1:0] status_init;

    always_comb begin
        if (state_init_i == ST_BLANK)     status_init = ST_BLANK;
        else if (state_init_i == ST_GOOD) status_init = ST_GOOD;
        else                              status_init = ST_FATAL;
    end

    assign done_o = seq_q.busy && (seq_q.cnt == LAST);

    always_comb begin
        seq_d = seq_q;
        if (start_i) begin
            seq_d.busy = 1'b1;
            seq_d.cnt  = '0;
        end else if (seq_q.busy) begin
            if (done_o) begin
                seq_d.busy   = 1'b0;
                seq_d.status = fuse_pass_i ? ST_GOOD : ST_FATAL;
            end else begin
                seq_d.cnt = seq_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '{busy: 1'b0, cnt: '0, status: status_init};
        else        seq_q <= seq_d;
    end

    assign busy_o   = seq_q.busy;
    assign status_o = seq_q.status;

    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.status != 2'b01); // R6
    AST_STATUS_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.status != ST_BLANK) |=> $stable(seq_q.status)); // R6
    AST_NO_BURN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.busy |-> (seq_q.status == ST_BLANK)); // R5
    AST_WINDOW_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(seq_q.busy) |-> (seq_q.status != ST_BLANK)); // R4
endmodule

// File: rtl/otp_wiper_chan.sv
module otp_wiper_chan #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] img_i,
    input  logic          img_valid_i,
    input  logic          wr_en_i,
    input  logic          ovr_wr_i,
    input  logic          ovr_load_i,
    input  logic [CW-1:0] data_i,
    input  logic          burn_done_i,
    input  logic          burn_pass_i,
    input  logic          locked_i,
    input  logic          ovr_act_i,
    input  logic          shdn_i,
    output logic [CW-1:0] code_o,
    output logic [CW-1:0] wreg_o
);
    localparam logic [CW-1:0] MID = {1'b1, {(CW-1){1'b0}}};

    typedef struct packed {
        logic [CW-1:0] wreg;
        logic [CW-1:0] ovrv;
        logic [CW-1:0] fimg;
    } chan_t;

    chan_t ch_d, ch_q;
    logic [CW-1:0] boot_code;
    logic [CW-1:0] sel_code;

    assign boot_code = img_valid_i ? img_i : MID;

    always_comb begin
        ch_d = ch_q;
        if (wr_en_i)    ch_d.wreg = data_i;
        if (ovr_load_i) ch_d.ovrv = ch_q.fimg;
        if (ovr_wr_i)   ch_d.ovrv = data_i;
        if (burn_done_i) ch_d.fimg = burn_pass_i ? ch_q.wreg : MID;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ch_q <= '{wreg: boot_code, ovrv: boot_code, fimg: boot_code};
        else        ch_q <= ch_d;
    end

    always_comb begin
        if (!locked_i)      sel_code = ch_q.wreg;
        else if (ovr_act_i) sel_code = ch_q.ovrv;
        else                sel_code = ch_q.fimg;
    end

    assign code_o = shdn_i ? '0 : sel_code;
    assign wreg_o = ch_q.wreg;

    AST_FUSED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_i && !burn_done_i) |=> $stable(ch_q.fimg)); // R5
endmodule

// File: rtl/otp_wiper_ctrl.sv
module otp_wiper_ctrl
    import otp_wiper_pkg::*;
#(
    parameter int NCH         = 2,
    parameter int CW          = 8,
    parameter int BURN_CYCLES = 80_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] cmd_chan_i,
    input  logic              cmd_shdn_i,
    input  logic              cmd_prog_i,
    input  logic              cmd_ovr_i,
    input  logic [CW-1:0]     cmd_data_i,
    input  logic [1:0]        fuse_state_i,
    input  logic [NCH*CW-1:0] fuse_img_i,
    input  logic              fuse_pass_i,
    output logic              burn_en_o,
    output logic [NCH*CW-1:0] burn_data_o,
    output logic              busy_o,
    output logic [1:0]        status_o,
    output logic              shdn_o,
    output logic [NCH*CW-1:0] code_o
);
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        logic shdn;
        logic ovr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic busy, done, locked, acc, norm, start;
    logic [1:0] status;

    otp_burn_seq #(.BURN_CYCLES(BURN_CYCLES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_init_i(fuse_state_i),
        .start_i     (start),
        .fuse_pass_i (fuse_pass_i),
        .busy_o      (busy),
        .done_o      (done),
        .status_o    (status)
    );

    assign locked = (status != ST_BLANK);
    assign acc    = cmd_valid_i && !busy;
    assign norm   = acc && !cmd_prog_i;
    assign start  = acc && cmd_prog_i && !locked;

    always_comb begin
        ctl_d = ctl_q;
        if (start) begin
            ctl_d.ovr = 1'b0;
        end else if (norm) begin
            ctl_d.shdn = cmd_shdn_i;
            ctl_d.ovr  = cmd_ovr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{shdn: 1'b0, ovr: 1'b0};
        else        ctl_q <= ctl_d;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit;
        assign hit = norm && (cmd_chan_i == CH_W'(g));

        otp_wiper_chan #(.CW(CW)) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .img_i      (fuse_img_i[g*CW +: CW]),
            .img_valid_i(fuse_state_i == ST_GOOD),
            .wr_en_i    (hit && !(locked && cmd_ovr_i)),
            .ovr_wr_i   (hit && locked && cmd_ovr_i),
            .ovr_load_i (norm && locked && cmd_ovr_i && !ctl_q.ovr),
            .data_i     (cmd_data_i),
            .burn_done_i(done),
            .burn_pass_i(fuse_pass_i),
            .locked_i   (locked),
            .ovr_act_i  (ctl_q.ovr),
            .shdn_i     (ctl_q.shdn),
            .code_o     (code_o[g*CW +: CW]),
            .wreg_o     (burn_data_o[g*CW +: CW])
        );
    end

    assign burn_en_o = busy;
    assign busy_o    = busy;
    assign status_o  = status;
    assign shdn_o    = ctl_q.shdn;

    AST_BUSY_FREEZES_MODES: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(ctl_q.shdn) && $stable(ctl_q.ovr))); // R3
    AST_FUSED_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !ctl_q.ovr && !ctl_q.shdn) |=> (ctl_q.ovr || ctl_q.shdn || $stable(code_o))); // R8
endmodule

// File: tb/sim_otp_wiper_ctrl.sv
module sim_otp_wiper_ctrl;
    localparam int NCH   = 2;
    localparam int CW    = 8;
    localparam int BURN  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_chan = 1'b0, cmd_shdn = 1'b0, cmd_prog = 1'b0, cmd_ovr = 1'b0;
    logic [7:0] cmd_data = 8'h00;
    logic fuse_pass = 1'b0;
    logic [1:0] fa_state = 2'b00;
    logic [15:0] fa_img = 16'h0000;
    logic burn_en, busy, shdn;
    logic [15:0] burn_data, code;
    logic [1:0] status;

    int n_run = 0, n_fail = 0, cycles = 0, busy_cnt = 0;
    bit started = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_st, m_shdn, m_ovr, m_busy, m_cnt;
    int m_wreg[2], m_ovrv[2], m_fimg[2];

    always #2.5 clk = ~clk;

    otp_wiper_ctrl #(.NCH(NCH), .CW(CW), .BURN_CYCLES(BURN)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_chan_i(cmd_chan),
        .cmd_shdn_i(cmd_shdn), .cmd_prog_i(cmd_prog), .cmd_ovr_i(cmd_ovr),
        .cmd_data_i(cmd_data), .fuse_state_i(fa_state), .fuse_img_i(fa_img),
        .fuse_pass_i(fuse_pass), .burn_en_o(burn_en), .burn_data_o(burn_data),
        .busy_o(busy), .status_o(status), .shdn_o(shdn), .code_o(code)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = (fa_state == 2'b00) ? 0 : (fa_state == 2'b11) ? 3 : 2;
            for (int c = 0; c < 2; c++) begin
                m_fimg[c] = (m_st == 3) ? int'(fa_img[c*8 +: 8]) : 8'h80;
                m_wreg[c] = m_fimg[c];
                m_ovrv[c] = m_fimg[c];
            end
            m_shdn = 0; m_ovr = 0; m_busy = 0; m_cnt = 0;
            started = 1;
        end else if (m_busy != 0) begin
            m_cnt++;
            if (m_cnt == BURN) begin
                m_busy = 0;
                if (fuse_pass) begin
                    m_st = 3;
                    for (int c = 0; c < 2; c++) m_fimg[c] = m_wreg[c];
                end else begin
                    m_st = 2;
                    for (int c = 0; c < 2; c++) m_fimg[c] = 8'h80;
                end
                fa_state = (m_st == 3) ? 2'b11 : 2'b10;
                fa_img = {m_fimg[1][7:0], m_fimg[0][7:0]};
            end
        end else if (cmd_valid) begin
            if (cmd_prog) begin
                if (m_st == 0) begin m_busy = 1; m_cnt = 0; m_ovr = 0; end
            end else begin
                if (m_st != 0 && cmd_ovr) begin
                    if (m_ovr == 0) for (int c = 0; c < 2; c++) m_ovrv[c] = m_fimg[c];
                    m_ovrv[cmd_chan] = cmd_data;
                end else begin
                    m_wreg[cmd_chan] = cmd_data;
                end
                m_shdn = cmd_shdn;
                m_ovr = cmd_ovr;
            end
        end
    end

    function automatic int exp_code(int c);
        if (m_shdn != 0) return 0;
        if (m_st == 0) return m_wreg[c];
        if (m_ovr != 0) return m_ovrv[c];
        return m_fimg[c];
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (busy) busy_cnt++;
        if (started && rst_n) begin
            chk(cur_req, "code0", int'(code[7:0]), exp_code(0));
            chk(cur_req, "code1", int'(code[15:8]), exp_code(1));
            chk(cur_req, "status", int'(status), m_st);
            chk(cur_req, "busy", int'(busy), m_busy);
            chk(cur_req, "burn_en", int'(burn_en), m_busy);
            chk(cur_req, "shdn", int'(shdn), m_shdn);
            chk("R6", "status legal", int'(status == 2'b01), 0);
            if (m_busy != 0)
                chk("R3", "burn_data", int'(burn_data), (m_wreg[1] << 8) | m_wreg[0]);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic cmd(bit ch, bit sd, bit pg, bit ov, logic [7:0] d);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_chan = ch; cmd_shdn = sd; cmd_prog = pg; cmd_ovr = ov; cmd_data = d;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        // fresh blank part
        cur_req = "R1";
        do_reset();
        chk("R1", "blank code", int'(code), 16'h8080);
        chk("R1", "blank status", int'(status), 0);
        chk("R1", "busy", int'(busy), 0);

        cur_req = "R2";
        cmd(0, 0, 0, 0, 8'h12);
        chk("R2", "write ch0", int'(code[7:0]), 8'h12);
        cmd(1, 0, 0, 0, 8'hF0);
        chk("R2", "write ch1", int'(code), 16'hF012);
        for (int i = 1; i <= 5; i++) cmd(0, 0, 0, 0, 8'(i * 8'h11));
        chk("R2", "repeated writes", int'(code[7:0]), 8'h55);
        cmd(1, 0, 0, 1, 8'h3C);
        chk("R2", "overwrite bit while blank", int'(code), 16'h3C55);

        cur_req = "R10";
        cmd(0, 1, 0, 0, 8'h77);
        chk("R10", "shutdown zero", int'(code), 0);
        chk("R10", "shutdown flag", int'(shdn), 1);
        cmd(1, 0, 0, 0, 8'h44);
        chk("R10", "release shows stored", int'(code), 16'h4477);

        cur_req = "R3";
        fuse_pass = 1'b1;
        busy_cnt = 0;
        cmd(0, 1, 1, 1, 8'h99);
        chk("R3", "busy after program", int'(busy), 1);
        chk("R3", "burn data", int'(burn_data), 16'h4477);
        chk("R3", "program fields ignored", int'(shdn), 0);
        cmd(0, 0, 0, 0, 8'h01);
        chk("R3", "command during burn ignored", int'(code[7:0]), 8'h77);
        wait_idle();
        chk("R3", "window length", busy_cnt, BURN);
        cur_req = "R4";
        chk("R4", "status good", int'(status), 3);
        chk("R4", "fused codes", int'(code), 16'h4477);

        cur_req = "R8";
        cmd(0, 0, 0, 0, 8'h05);
        chk("R8", "locked write not applied", int'(code[7:0]), 8'h77);
        cur_req = "R5";
        cmd(0, 0, 1, 0, 8'h00);
        chk("R5", "second program ignored", int'(busy), 0);
        chk("R5", "status held", int'(status), 3);

        cur_req = "R7";
        cmd(1, 0, 0, 1, 8'hAB);
        chk("R7", "overwrite ch1", int'(code), 16'hAB77);
        cmd(0, 0, 0, 1, 8'hCD);
        chk("R7", "overwrite ch0", int'(code), 16'hABCD);
        cur_req = "R8";
        cmd(1, 0, 0, 0, 8'h10);
        chk("R8", "overwrite cleared", int'(code), 16'h4477);

        cur_req = "R9";
        cmd(0, 0, 0, 1, 8'hEE);
        chk("R9", "overwrite before reset", int'(code[7:0]), 8'hEE);
        do_reset();
        chk("R9", "fused after reset", int'(code), 16'h4477);
        chk("R1", "status from fuses", int'(status), 3);

        // second part, failing burn
        cur_req = "R1";
        fa_state = 2'b00; fa_img = 16'h0000;
        do_reset();
        cur_req = "R4";
        cmd(0, 0, 0, 0, 8'h20);
        fuse_pass = 1'b0;
        cmd(1, 0, 1, 0, 8'h00);
        wait_idle();
        chk("R4", "status fatal", int'(status), 2);
        chk("R4", "midscale after fail", int'(code), 16'h8080);
        cmd(0, 0, 0, 0, 8'h30);
        chk("R8", "fatal part write not applied", int'(code[7:0]), 8'h80);
        cur_req = "R7";
        cmd(0, 0, 0, 1, 8'h31);
        chk("R7", "overwrite on fatal part", int'(code), 16'h8031);
        cur_req = "R1";
        do_reset();
        chk("R1", "fatal status at reset", int'(status), 2);
        chk("R1", "fatal codes at reset", int'(code), 16'h8080);
        cur_req = "R5";
        cmd(0, 0, 1, 0, 8'h00);
        chk("R5", "no retry", int'(busy), 0);
        repeat (3) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule